// File: doc/BRIEF.md
# Performance Counter Unit

This block counts hardware events for software profiling. It has a parameterised set of general-purpose counters and three fixed-function counters. The fixed counters count retired instructions, unhalted core clock cycles and unhalted bus clock cycles. Event pulses arrive one per counter per clock on plain input pins. A mode input tells the block whether the core is in user or kernel mode. Each counter decides every cycle whether that pulse counts.

Software reaches the unit through a single-cycle register port. Writes land on the next rising edge. Reads are combinational from the held address. There is no stream on this block, so the port is plain, with no valid/ready handshake and no back-pressure.

Software uses the registers in this way:
- It preloads a counter with the two's-complement of a sampling period.
- It enables the counter.
- It takes an interrupt when the counter wraps.
- It clears the overflow through a separate acknowledge register.

A strap input selects a variant in which acknowledges only take effect while global enable is nonzero.

Top module: `pmu_unit`

## Requirements
- R1: After reset, every register and counter reads zero and `irq_o` is low.
- R2: The fixed-counter control register holds one 4-bit field per fixed counter, at bit offset 4*index. In each field, bit 0 enables kernel-mode counting, bit 1 enables user-mode counting and bit 3 enables the overflow interrupt. Fixed counter 0 takes `fix_ev_i[0]` (retired instructions), counter 1 takes `fix_ev_i[1]` (core cycles) and counter 2 takes `fix_ev_i[2]` (bus cycles).
- R3: A counter adds one on a clock edge only when all of the following hold:
  - its global enable bit is set. General counter i uses bit i and fixed counter j uses bit 32+j.
  - its local enable is set.
  - `mode_usr_i` (1 = user, 0 = kernel) matches one of its enabled mode bits.
  - its qualified event is high.
- R4: Writing zero to global enable freezes every counter at its value, and rewriting the enable mask resumes counting from there.
- R5: A counter wraps from all ones (48 bits) to zero. On the same edge, its bit in global status (same position as in global enable) is set.
- R6: Writing a mask to the acknowledge register clears those status bits. An overflow on the same edge as its acknowledge still leaves its bit set.
- R7: With `ack_gate_i` high, acknowledge writes are ignored while global enable is zero. With `ack_gate_i` low, they always take effect.
- R8: `irq_o` is high while any status bit below 63 is set whose counter has its interrupt enable set. Bit 63 never raises it.
- R9: Status bit 63 is a condition-changed flag. A write that changes the global enable value sets it, and it is cleared like any other bit through the acknowledge register.
- R10: The general event-select register has these fields:
  - event code in bits 7:0 and unit mask in bits 15:8
  - user enable at bit 16 and kernel enable at bit 17
  - edge detect at bit 18
  - interrupt enable at bit 20
  - counter enable at bit 22
  - invert at bit 23
  - threshold in bits 31:24

  The register reads back as written. Invert counts cycles where the event is low, and edge detect counts only rising edges of the (possibly inverted) event.
- R11: Every counter can be written through the port to preload a period. A write beats an increment on the same edge.
- R12: Address map:

  | Address | Register |
  |---|---|
  | 0 | global enable |
  | 1 | status (read) |
  | 2 | acknowledge (write only, reads zero) |
  | 3 | fixed control |
  | 4+i | event select i |
  | 8+i | general counter i |
  | 12+j | fixed counter j |

  Unimplemented addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_gate_i | input | 1 | Variant select: acknowledge needs global enable nonzero |
| mode_usr_i | input | 1 | Current privilege mode, 1 user, 0 kernel |
| fix_ev_i | input | NUM_FIX | Event pulses for fixed counters |
| gp_ev_i | input | NUM_GP | Event pulses for general counters |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data for the held address |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is an overflow that lands on the same clock edge as an acknowledge of that same bit. Only then can the rule that a fresh overflow outlives its acknowledge be observed.

The stimulus first preloads the counter to all ones. It then raises the event pulse and the acknowledge write in the same cycle, and reads status on the next one.

The gated acknowledge variant is reached by clearing global enable while an interrupting overflow is pending. With nothing counting, the acknowledge must then leave status and the interrupt untouched.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // register addresses
  localparam int A_GLB     = 0;
  localparam int A_STAT    = 1;
  localparam int A_ACK     = 2;
  localparam int A_FIXC    = 3;
  localparam int A_EVSEL0  = 4;
  localparam int A_GPCNT0  = 8;
  localparam int A_FIXCNT0 = 12;

  // bit placement in enable/status words
  localparam int FIX_BASE = 32;
  localparam int CHG_BIT  = 63;

  // fixed-control nibble
  localparam int FN_W   = 4;
  localparam int FN_KRN = 0;
  localparam int FN_USR = 1;
  localparam int FN_IE  = 3;

  // event-select fields
  localparam int ES_W    = 32;
  localparam int ES_USR  = 16;
  localparam int ES_KRN  = 17;
  localparam int ES_EDGE = 18;
  localparam int ES_IE   = 20;
  localparam int ES_EN   = 22;
  localparam int ES_INV  = 23;
endpackage

// File: rtl/pmu_evt_qual.sv
module pmu_evt_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic inv_i,
  input  logic edge_i,
  output logic pulse_o
);
  logic raw, raw_q;

  assign raw = ev_i ^ inv_i;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw;
  end

  assign pulse_o = edge_i ? (raw & ~raw_q) : raw;

  // R10
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && pulse_o) |=> (!pulse_o || !edge_i));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  assign ovf_o = inc_i & ~load_i & (&cnt_o);

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_o == $past(load_val_i));
  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && (&cnt_o)) |=> cnt_o == '0);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
  import pmu_pkg::*;
#(
  parameter int NUM_GP  = 2,
  parameter int NUM_FIX = 3,
  parameter int CNT_W   = 48,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_gate_i,
  input  logic               mode_usr_i,
  input  logic [NUM_FIX-1:0] fix_ev_i,
  input  logic [NUM_GP-1:0]  gp_ev_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [63:0]        reg_wdata_i,
  output logic [63:0]        reg_rdata_o,
  output logic               irq_o
);
  // NUM_GP and NUM_FIX are each limited to 4 by the address map
  localparam logic [63:0] GP_MASK  = (64'(1) << NUM_GP) - 64'(1);
  localparam logic [63:0] FIX_MASK = ((64'(1) << NUM_FIX) - 64'(1)) << FIX_BASE;
  localparam logic [63:0] GLB_MASK = GP_MASK | FIX_MASK;
  localparam int          FC_W     = FN_W * NUM_FIX;

  logic [63:0]      glb_q, stat_q, stat_nxt, ovf64, ie64;
  logic [FC_W-1:0]  fixc_q;
  logic [ES_W-1:0]  evsel_q [NUM_GP];
  logic [CNT_W-1:0] gp_cnt  [NUM_GP];
  logic [CNT_W-1:0] fix_cnt [NUM_FIX];
  logic [NUM_GP-1:0]  gp_ovf;
  logic [NUM_FIX-1:0] fix_ovf;
  logic glb_wr, ack_wr, ack_fire, glb_chg;

  assign glb_wr   = reg_we_i && (reg_addr_i == ADDR_W'(A_GLB));
  assign ack_wr   = reg_we_i && (reg_addr_i == ADDR_W'(A_ACK));
  assign ack_fire = ack_wr && (!ack_gate_i || (glb_q != '0));
  assign glb_chg  = glb_wr && ((reg_wdata_i & GLB_MASK) != glb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_q  <= '0;
      fixc_q <= '0;
    end else begin
      if (glb_wr) glb_q <= reg_wdata_i & GLB_MASK;
      if (reg_we_i && (reg_addr_i == ADDR_W'(A_FIXC))) fixc_q <= reg_wdata_i[FC_W-1:0];
    end
  end

  // general-purpose counters
  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    logic pulse, mode_ok;

    always_ff @(posedge clk) begin
      if (!rst_n) evsel_q[i] <= '0;
      else if (reg_we_i && (reg_addr_i == ADDR_W'(A_EVSEL0 + i)))
        evsel_q[i] <= reg_wdata_i[ES_W-1:0];
    end

    pmu_evt_qual u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (gp_ev_i[i]),
      .inv_i  (evsel_q[i][ES_INV]),
      .edge_i (evsel_q[i][ES_EDGE]),
      .pulse_o(pulse)
    );

    assign mode_ok = mode_usr_i ? evsel_q[i][ES_USR] : evsel_q[i][ES_KRN];

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (glb_q[i] & evsel_q[i][ES_EN] & mode_ok & pulse),
      .load_i    (reg_we_i && (reg_addr_i == ADDR_W'(A_GPCNT0 + i))),
      .load_val_i(reg_wdata_i[CNT_W-1:0]),
      .cnt_o     (gp_cnt[i]),
      .ovf_o     (gp_ovf[i])
    );
  end

  // fixed-function counters
  for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
    logic [FN_W-1:0] nib;
    logic            mode_ok;

    assign nib     = fixc_q[FN_W*j +: FN_W];
    assign mode_ok = mode_usr_i ? nib[FN_USR] : nib[FN_KRN];

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (glb_q[FIX_BASE+j] & mode_ok & fix_ev_i[j]),
      .load_i    (reg_we_i && (reg_addr_i == ADDR_W'(A_FIXCNT0 + j))),
      .load_val_i(reg_wdata_i[CNT_W-1:0]),
      .cnt_o     (fix_cnt[j]),
      .ovf_o     (fix_ovf[j])
    );
  end

  always_comb begin
    ovf64 = '0;
    ie64  = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      ovf64[i] = gp_ovf[i];
      ie64[i]  = evsel_q[i][ES_IE];
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      ovf64[FIX_BASE+j] = fix_ovf[j];
      ie64[FIX_BASE+j]  = fixc_q[FN_W*j + FN_IE];
    end
  end

  // status: acknowledge first, then new overflows win
  always_comb begin
    stat_nxt = stat_q;
    if (ack_fire) stat_nxt = stat_nxt & ~reg_wdata_i;
    stat_nxt = stat_nxt | ovf64;
    if (glb_chg) stat_nxt[CHG_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  assign irq_o = |(stat_q[CHG_BIT-1:0] & ie64[CHG_BIT-1:0]);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_GLB))  reg_rdata_o = glb_q;
    if (reg_addr_i == ADDR_W'(A_STAT)) reg_rdata_o = stat_q;
    if (reg_addr_i == ADDR_W'(A_FIXC)) reg_rdata_o = 64'(fixc_q);
    for (int i = 0; i < NUM_GP; i++) begin
      if (reg_addr_i == ADDR_W'(A_EVSEL0 + i)) reg_rdata_o = 64'(evsel_q[i]);
      if (reg_addr_i == ADDR_W'(A_GPCNT0 + i)) reg_rdata_o = 64'(gp_cnt[i]);
    end
    for (int j = 0; j < NUM_FIX; j++)
      if (reg_addr_i == ADDR_W'(A_FIXCNT0 + j)) reg_rdata_o = 64'(fix_cnt[j]);
  end

  // R5
  ovf_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf64[CHG_BIT-1:0]) |=>
      ((stat_q[CHG_BIT-1:0] & $past(ovf64[CHG_BIT-1:0])) == $past(ovf64[CHG_BIT-1:0])));
  // R7
  gated_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_gate_i && ack_wr && glb_q == '0) |=> $stable(stat_q));
  // R9
  cond_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_wr && ((reg_wdata_i & GLB_MASK) != glb_q)) |=> stat_q[CHG_BIT]);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(|ovf64) || $past(reg_we_i)));
endmodule

// File: tb/pmu_unit_tb.sv
module pmu_unit_tb;
  localparam int CLK_P = 10;
  localparam logic [63:0] ALL_EN = 64'h7_0000_0003;
  localparam logic [63:0] ONES48 = 64'hFFFF_FFFF_FFFF;
  localparam logic [63:0] CHG    = 64'h1 << 63;

  logic clk = 1'b0, rst_n = 1'b0, ack_gate = 1'b0, mode_usr = 1'b0;
  logic [2:0]  fix_ev = '0;
  logic [1:0]  gp_ev  = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        irq;

  typedef struct { int kind; logic [3:0] a; logic [63:0] exp; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pmu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ack_gate_i(ack_gate), .mode_usr_i(mode_usr),
    .fix_ev_i(fix_ev), .gp_ev_i(gp_ev), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops expected items and compares after the falling edge
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it  = q.pop_front();
      act = (it.kind == 1) ? {63'b0, irq} : rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [63:0] e, input string tag);
    addr = a;
    q.push_back('{0, a, e, tag});
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    q.push_back('{1, 4'd0, {63'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] f, input logic [1:0] g, input logic usr, input int n);
    fix_ev = f; gp_ev = g; mode_usr = usr;
    repeat (n) @(negedge clk);
    fix_ev = '0; gp_ev = '0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog (R1..): actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(0, 0, "R1 global enable");
    chk(1, 0, "R1 status");
    chk(12, 0, "R1 fixed counter 0");
    chk(4, 0, "R1 event select 0");
    chk_irq(1'b0, "R1 irq low");
    // R2 fixed nibbles: fx0 int+usr+krn, fx1 usr, fx2 krn
    wr(3, 64'h12B);
    chk(3, 64'h12B, "R2 fixed control readback");
    wr(0, ALL_EN);
    chk(0, ALL_EN, "R3 global enable readback");
    chk(1, CHG, "R9 change flag set");
    chk_irq(1'b0, "R9 change flag no irq");
    wr(2, CHG);
    chk(1, 0, "R9 change flag acked");
    run(3'b111, 2'b00, 1'b1, 5);
    chk(12, 5, "R2 fx0 user");
    chk(13, 5, "R2 fx1 user");
    chk(14, 0, "R3 fx2 no user count");
    run(3'b111, 2'b00, 1'b0, 3);
    chk(12, 8, "R2 fx0 kernel");
    chk(13, 5, "R3 fx1 no kernel count");
    chk(14, 3, "R2 fx2 kernel");
    // R4 freeze and resume
    wr(0, 0);
    run(3'b111, 2'b00, 1'b1, 4);
    chk(12, 8, "R4 fx0 frozen");
    chk(13, 5, "R4 fx1 frozen");
    wr(0, ALL_EN);
    run(3'b111, 2'b00, 1'b1, 2);
    chk(12, 10, "R4 fx0 resumed");
    chk(13, 7, "R4 fx1 resumed");
    wr(2, CHG);
    chk(1, 0, "R6 status cleared");
    // R5 wrap on fixed counter 0
    wr(12, ONES48 - 1);
    chk(12, ONES48 - 1, "R11 preload");
    run(3'b001, 2'b00, 1'b0, 1);
    chk(12, ONES48, "R5 all ones");
    chk(1, 0, "R5 no early overflow");
    run(3'b001, 2'b00, 1'b0, 1);
    chk(12, 0, "R5 wrapped to zero");
    chk(1, 64'h1 << 32, "R5 status bit 32");
    chk_irq(1'b1, "R8 irq on fx0 overflow");
    // R7 gated acknowledge
    ack_gate = 1'b1;
    wr(0, 0);
    wr(2, 64'h1 << 32);
    chk(1, (64'h1 << 32) | CHG, "R7 ack ignored while disabled");
    chk_irq(1'b1, "R7 irq held");
    wr(0, ALL_EN);
    wr(2, (64'h1 << 32) | CHG);
    chk(1, 0, "R7 ack accepted while enabled");
    chk_irq(1'b0, "R6 irq cleared");
    ack_gate = 1'b0;
    // R8 overflow without interrupt enable
    wr(13, ONES48);
    run(3'b010, 2'b00, 1'b1, 1);
    chk(1, 64'h1 << 33, "R8 fx1 status");
    chk_irq(1'b0, "R8 no irq without enable");
    wr(0, 0);
    wr(2, 64'h1 << 33);
    chk(1, CHG, "R6 ungated ack while disabled");
    wr(0, ALL_EN);
    wr(2, CHG);
    // R6 overflow and acknowledge on the same edge
    wr(14, ONES48);
    we = 1'b1; addr = 4'd2; wdata = 64'h1 << 34; fix_ev = 3'b100; mode_usr = 1'b0;
    @(negedge clk);
    we = 1'b0; fix_ev = '0;
    chk(1, 64'h1 << 34, "R6 new overflow survives ack");
    chk(14, 0, "R5 fx2 wrapped");
    wr(2, 64'h1 << 34);
    chk(1, 0, "R6 fx2 acked");
    // R11 write beats increment
    we = 1'b1; addr = 4'd12; wdata = 64'd100; fix_ev = 3'b001; mode_usr = 1'b1;
    @(negedge clk);
    we = 1'b0; fix_ev = '0;
    chk(12, 100, "R11 write priority");
    // R10 general counters
    wr(4, 64'h0553_013C);
    chk(4, 64'h0553_013C, "R10 event select readback");
    run(3'b000, 2'b01, 1'b1, 6);
    chk(8, 6, "R10 gp0 level count");
    wr(5, 64'h0003_0000);
    run(3'b000, 2'b10, 1'b1, 5);
    chk(9, 0, "R3 gp1 local enable off");
    // R10 invert: gp1 counts idle cycles while enabled
    wr(0, 64'h7_0000_0001);
    wr(5, 64'h00C3_0000);
    wr(0, ALL_EN);
    repeat (3) @(negedge clk);
    wr(0, 64'h7_0000_0001);
    chk(9, 4, "R10 invert counts low cycles");
    // R10 edge detect on gp0
    wr(4, 64'h0557_013C);
    mode_usr = 1'b1;
    foreach (ALL_EN[k]) if (k < 8) begin
      gp_ev[0] = (k == 0 || k == 2 || k == 4 || k == 5 || k == 6);
      @(negedge clk);
    end
    gp_ev = '0;
    chk(8, 9, "R10 edge counts rising edges");
    // R8 gp0 overflow with interrupt
    wr(8, ONES48);
    run(3'b000, 2'b01, 1'b1, 1);
    chk(1, 64'h1 | CHG, "R5 gp0 status bit 0");
    chk_irq(1'b1, "R8 gp0 irq");
    wr(2, 64'h1 | CHG);
    chk(1, 0, "R6 gp0 acked");
    chk_irq(1'b0, "R8 irq dropped");
    // R12 address map
    chk(2, 0, "R12 ack reads zero");
    chk(6, 0, "R12 absent event select");
    chk(15, 0, "R12 absent fixed counter");
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule